// File: doc/BRIEF.md
# Dual-Channel Sample-Ready Controller

This block sits between two converter channels and the serial shifter that reads their results. Each channel raises a one-cycle ready strobe with its result word. From those strobes the block forms one active-low ready pin, plus an output enable for that pin. A 2-bit routing field chooses which channel's events reach the pin. Its four settings are channel 0 only, channel 1 only, both channels, or a linked mode that waits for both channels and fires once on the later of the two.

Results pass through two register stages. The first stage captures a channel's word when that channel is ready. In linked mode it captures both words together, at the moment the later channel is ready. The second stage is what the shifter reads. It follows the first stage until a read of that channel starts. It then stays frozen until the shifter signals that every bit has been taken, so a read never mixes old and new words or returns a torn word.

Pulses are timed by a modulator-clock enable. Events that arrive close together are queued. Each queued event produces its own pulse, and each pulse is separated from the next.

Top module: `dual_ready_latch`

## Requirements
- R1: While the pin is not pulsing, `dr_o` is 1 and `dr_oe` equals `idle_drive`: 0 leaves the pin undriven, 1 drives it high. During a pulse, `dr_o` is 0 and `dr_oe` is 1.
- R2: A pulse changes level only on a clock edge where `mclk_en` is 1. It is low for exactly one modulator period, meaning from one `mclk_en` cycle up to the next one.
- R3: `mode` 2'b01 routes only channel 0 events to the pin, 2'b10 routes only channel 1, and 2'b11 routes both. A ready strobe from a channel whose off flag is set has no effect. In 2'b11 the awake channel still produces pulses.
- R4: With `mode` 2'b00, one pulse follows only after both channels have been ready, and it is triggered by the later of the two. Both first-stage words are loaded together at that edge.
- R5: With `mode` 2'b00, any channel off flag discards the pending ready state of both channels, and no pulse is produced.
- R6: With `mode` 2'b00, a channel that becomes ready more than once before the other keeps only its newest word.
- R7: `rd_start0`/`rd_start1` freeze the matching readout word from the next edge onward. The word stays frozen until the edge after the matching `rd_done0`/`rd_done1`. Newer results are presented only after that.
- R8: Every routed event gives its own pulse, with at least one idle modulator period between pulses. Up to 3 events are held pending, so two simultaneous events in mode 2'b11 give two pulses.
- R9: While `rst_n` is 0, the pin is inactive, no events are pending, and both readout words are 0.
- R10: Outside a read, a readout word shows its first-stage word two edges after the ready strobe. In the single-channel and both-channel modes, a channel's word is captured even when its events are not routed to the pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low master reset |
| mclk_en | input | 1 | One-cycle tick per modulator period |
| mode | input | 2 | Pin routing: 00 linked, 01 ch0, 10 ch1, 11 both |
| idle_drive | input | 1 | 1 drives the idle pin high, 0 leaves it undriven |
| ch0_rdy | input | 1 | Channel 0 result-ready strobe |
| ch0_data | input | W | Channel 0 result word |
| ch0_off | input | 1 | Channel 0 in reset or shutdown |
| ch1_rdy | input | 1 | Channel 1 result-ready strobe |
| ch1_data | input | W | Channel 1 result word |
| ch1_off | input | 1 | Channel 1 in reset or shutdown |
| rd_start0 | input | 1 | Read of channel 0 word begins |
| rd_done0 | input | 1 | Last bit of channel 0 word taken |
| rd_start1 | input | 1 | Read of channel 1 word begins |
| rd_done1 | input | 1 | Last bit of channel 1 word taken |
| dr_o | output | 1 | Ready pin level, active low |
| dr_oe | output | 1 | Ready pin output enable |
| out0 | output | W | Channel 0 readout word |
| out1 | output | W | Channel 1 readout word |

## Verification
A result word reaches its readout port on the second clock edge after the ready strobe: first the capture stage, then the readout stage. The bench therefore samples the readout ports on the falling edge after that second rising edge. A queued event starts its pulse at the first `mclk_en` edge after the edge that queued it. The pulse then stays low for the full modulator period, which is four clocks in this bench. Pulse counts are collected over windows long enough to hold every due pulse. A cycle-level reference model, driven by the same inputs, predicts the pin and both readout words, and these are compared on every falling clock edge.

// File: rtl/dual_ready_latch.sv
module dual_ready_latch #(
  parameter int W  = 24,
  parameter int PW = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mclk_en,
  input  logic [1:0]   mode,
  input  logic         idle_drive,
  input  logic         ch0_rdy,
  input  logic [W-1:0] ch0_data,
  input  logic         ch0_off,
  input  logic         ch1_rdy,
  input  logic [W-1:0] ch1_data,
  input  logic         ch1_off,
  input  logic         rd_start0,
  input  logic         rd_done0,
  input  logic         rd_start1,
  input  logic         rd_done1,
  output logic         dr_o,
  output logic         dr_oe,
  output logic [W-1:0] out0,
  output logic [W-1:0] out1
);
  localparam int SW = PW + 2;
  localparam logic [SW-1:0] PMAX = SW'((1 << PW) - 1);

  logic         r0, r1, linked, any_off, both, fire, take, act;
  logic         f0, f1, b0, b1;
  logic [W-1:0] p0, p1, s0, s1;
  logic [1:0]   nevt;
  logic [PW-1:0] pend;
  logic [SW-1:0] sum;

  assign r0      = ch0_rdy & ~ch0_off;
  assign r1      = ch1_rdy & ~ch1_off;
  assign linked  = (mode == 2'b00);
  assign any_off = ch0_off | ch1_off;
  assign both    = (f0 | r0) & (f1 | r1);
  assign fire    = linked & both & ~any_off;
  assign nevt    = linked ? {1'b0, fire}
                          : ({1'b0, mode[0] & r0} + {1'b0, mode[1] & r1});
  assign take    = mclk_en & ~act & (pend != '0);
  assign sum     = SW'(pend) + SW'(nevt) - SW'(take);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f0 <= 1'b0;
      f1 <= 1'b0;
    end else if (!linked || any_off || fire) begin
      f0 <= 1'b0;
      f1 <= 1'b0;
    end else begin
      f0 <= f0 | r0;
      f1 <= f1 | r1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p0 <= '0;
      p1 <= '0;
      s0 <= '0;
      s1 <= '0;
    end else begin
      if (r0) p0 <= ch0_data;
      if (r1) p1 <= ch1_data;
      if (linked) begin
        if (fire) begin
          s0 <= r0 ? ch0_data : p0;
          s1 <= r1 ? ch1_data : p1;
        end
      end else begin
        if (r0) s0 <= ch0_data;
        if (r1) s1 <= ch1_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b0   <= 1'b0;
      b1   <= 1'b0;
      out0 <= '0;
      out1 <= '0;
    end else begin
      if (!b0) out0 <= s0;
      if (!b1) out1 <= s1;
      if (rd_done0)       b0 <= 1'b0;
      else if (rd_start0) b0 <= 1'b1;
      if (rd_done1)       b1 <= 1'b0;
      else if (rd_start1) b1 <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= '0;
      act  <= 1'b0;
    end else begin
      pend <= (sum > PMAX) ? PMAX[PW-1:0] : sum[PW-1:0];
      if (mclk_en) act <= act ? 1'b0 : (pend != '0);
    end
  end

  assign dr_o  = ~act;
  assign dr_oe = act | idle_drive;
endmodule

module drl_checker #(
  parameter int W = 24
) (
  input logic         clk,
  input logic         rst_n,
  input logic         mclk_en,
  input logic [1:0]   mode,
  input logic         idle_drive,
  input logic         ch0_off,
  input logic         ch1_off,
  input logic         dr_o,
  input logic         dr_oe,
  input logic [W-1:0] out0,
  input logic [W-1:0] out1,
  input logic         busy0,
  input logic         busy1,
  input logic         f0,
  input logic         f1
);
  a_r1_low_driven: assert property (@(posedge clk) disable iff (!rst_n)
    !dr_o |-> dr_oe);
  a_r1_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    dr_o |-> (dr_oe == idle_drive));
  a_r2_edge_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (dr_o != $past(dr_o)) |-> $past(mclk_en));
  a_r7_hold0: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy0) |-> $stable(out0));
  a_r7_hold1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy1) |-> $stable(out1));
  a_r5_off_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00 && (ch0_off || ch1_off)) |=> (!f0 && !f1));
endmodule

bind dual_ready_latch drl_checker #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mclk_en(mclk_en), .mode(mode),
  .idle_drive(idle_drive), .ch0_off(ch0_off), .ch1_off(ch1_off),
  .dr_o(dr_o), .dr_oe(dr_oe), .out0(out0), .out1(out1),
  .busy0(b0), .busy1(b1), .f0(f0), .f1(f1)
);

// File: tb/dual_ready_latch_bench.sv
module dual_ready_latch_bench;
  localparam int W = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mclk_en = 1'b0;
  logic [1:0] mode = 2'b00;
  logic idle_drive = 1'b1;
  logic ch0_rdy = 1'b0, ch1_rdy = 1'b0, ch0_off = 1'b0, ch1_off = 1'b0;
  logic [W-1:0] ch0_data = '0, ch1_data = '0;
  logic rd_start0 = 1'b0, rd_done0 = 1'b0, rd_start1 = 1'b0, rd_done1 = 1'b0;
  logic dr_o, dr_oe;
  logic [W-1:0] out0, out1;

  int compared = 0, mismatched = 0;
  int pulses = 0, low_len = 0, last_low = 0;
  logic prev_dr = 1'b1;
  logic [1:0] tick_cnt = 2'd0;

  always #5 clk = ~clk;

  dual_ready_latch #(.W(W)) u_dual_ready_latch (
    .clk(clk), .rst_n(rst_n), .mclk_en(mclk_en), .mode(mode),
    .idle_drive(idle_drive), .ch0_rdy(ch0_rdy), .ch0_data(ch0_data),
    .ch0_off(ch0_off), .ch1_rdy(ch1_rdy), .ch1_data(ch1_data),
    .ch1_off(ch1_off), .rd_start0(rd_start0), .rd_done0(rd_done0),
    .rd_start1(rd_start1), .rd_done1(rd_done1), .dr_o(dr_o), .dr_oe(dr_oe),
    .out0(out0), .out1(out1));

  always @(negedge clk) begin
    tick_cnt <= tick_cnt + 2'd1;
    mclk_en  <= (tick_cnt == 2'd3);
  end

  // reference model
  logic m_act, m_f0, m_f1, m_b0, m_b1;
  logic [W-1:0] m_p0, m_p1, m_s0, m_s1, m_o0, m_o1;
  int m_pend;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_act = 0; m_f0 = 0; m_f1 = 0; m_b0 = 0; m_b1 = 0; m_pend = 0;
      m_p0 = '0; m_p1 = '0; m_s0 = '0; m_s1 = '0; m_o0 = '0; m_o1 = '0;
    end else begin
      automatic logic a0 = ch0_rdy && !ch0_off;
      automatic logic a1 = ch1_rdy && !ch1_off;
      automatic int events = 0;
      automatic logic launch = mclk_en && !m_act && m_pend > 0;
      if (!m_b0) m_o0 = m_s0;
      if (!m_b1) m_o1 = m_s1;
      m_b0 = rd_done0 ? 1'b0 : (rd_start0 ? 1'b1 : m_b0);
      m_b1 = rd_done1 ? 1'b0 : (rd_start1 ? 1'b1 : m_b1);
      if (mode == 2'b00) begin
        if (ch0_off || ch1_off) begin
          m_f0 = 0; m_f1 = 0;
        end else begin
          if (a0) begin m_f0 = 1; m_p0 = ch0_data; end
          if (a1) begin m_f1 = 1; m_p1 = ch1_data; end
          if (m_f0 && m_f1) begin
            m_s0 = m_p0; m_s1 = m_p1; m_f0 = 0; m_f1 = 0; events = 1;
          end
        end
      end else begin
        m_f0 = 0; m_f1 = 0;
        if (a0) begin m_p0 = ch0_data; m_s0 = ch0_data; if (mode[0]) events++; end
        if (a1) begin m_p1 = ch1_data; m_s1 = ch1_data; if (mode[1]) events++; end
      end
      if (mclk_en) m_act = m_act ? 1'b0 : (m_pend > 0);
      m_pend = m_pend + events - (launch ? 1 : 0);
      if (m_pend > 3) m_pend = 3;
    end
  end

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_dr && !dr_o) pulses++;
      if (!dr_o) low_len++;
      else if (!prev_dr) begin last_low = low_len; low_len = 0; end
      prev_dr = dr_o;
      check("R2 R8 model dr_o", W'(dr_o), W'(!m_act));
      check("R1 model dr_oe", W'(dr_oe), W'(m_act || idle_drive));
      check("R7 R10 model out0", out0, m_o0);
      check("R7 R10 model out1", out1, m_o1);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rdy(input logic c0, input logic c1, input logic [W-1:0] d0, input logic [W-1:0] d1);
    @(negedge clk);
    ch0_rdy = c0; ch1_rdy = c1; ch0_data = d0; ch1_data = d1;
    @(negedge clk);
    ch0_rdy = 0; ch1_rdy = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    automatic int seed_v = $urandom(32'd2024);
    automatic int bsy0 = 0, bsy1 = 0;
    cyc(3);
    check("R9 reset dr_o", W'(dr_o), W'(1));
    check("R9 reset out0", out0, '0);
    idle_drive = 0;
    #1 check("R1 idle undriven", W'(dr_oe), W'(0));
    cyc(1);
    rst_n = 1;
    cyc(4);

    // linked mode: newest word kept, one pulse on later channel
    mode = 2'b00; pulses = 0;
    rdy(1, 0, 24'h00000A, 0);
    cyc(2);
    rdy(1, 0, 24'h00000B, 0);
    cyc(12);
    check("R4 no pulse on one channel", W'(pulses), W'(0));
    rdy(0, 1, 0, 24'h00000C);
    cyc(1);
    check("R6 newest word kept", out0, 24'h00000B);
    check("R4 joint capture", out1, 24'h00000C);
    cyc(14);
    check("R4 single pulse", W'(pulses), W'(1));
    check("R2 pulse width", W'(last_low), W'(4));

    // off flag in linked mode
    pulses = 0; ch1_off = 1;
    rdy(1, 0, 24'h000011, 0);
    cyc(4);
    ch1_off = 0;
    rdy(0, 1, 0, 24'h000022);
    cyc(14);
    check("R5 off discards pending", W'(pulses), W'(0));
    check("R5 words unchanged", out0, 24'h00000B);

    // routing modes
    mode = 2'b01; pulses = 0;
    rdy(0, 1, 0, 24'h000033);
    cyc(1);
    check("R10 unrouted word captured", out1, 24'h000033);
    cyc(14);
    check("R3 ch1 blocked in 01", W'(pulses), W'(0));
    rdy(1, 0, 24'h000044, 0);
    cyc(14);
    check("R3 ch0 passes in 01", W'(pulses), W'(1));
    mode = 2'b11; ch0_off = 1; pulses = 0;
    rdy(1, 1, 24'h000055, 24'h000066);
    cyc(14);
    check("R3 awake channel pulses", W'(pulses), W'(1));
    check("R3 off channel ignored", out0, 24'h000044);
    ch0_off = 0; pulses = 0;
    rdy(1, 1, 24'h000077, 24'h000088);
    cyc(26);
    check("R8 two simultaneous events", W'(pulses), W'(2));

    // read freeze
    mode = 2'b01;
    @(negedge clk) rd_start0 = 1;
    @(negedge clk) rd_start0 = 0;
    rdy(1, 0, 24'h000099, 0);
    cyc(4);
    check("R7 frozen during read", out0, 24'h000077);
    @(negedge clk) rd_done0 = 1;
    @(negedge clk) rd_done0 = 0;
    cyc(1);
    check("R7 updated after read", out0, 24'h000099);

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (i % 250 == 0) mode = 2'($urandom_range(0, 3));
      ch0_off = ($urandom_range(0, 39) == 0);
      ch1_off = ($urandom_range(0, 39) == 0);
      ch0_rdy = ($urandom_range(0, 6) == 0);
      ch1_rdy = ($urandom_range(0, 6) == 0);
      ch0_data = W'($urandom);
      ch1_data = W'($urandom);
      idle_drive = ($urandom_range(0, 99) == 0) ? ~idle_drive : idle_drive;
      rd_start0 = 0; rd_done0 = 0; rd_start1 = 0; rd_done1 = 0;
      if (bsy0 == 0) begin
        if ($urandom_range(0, 9) == 0) begin rd_start0 = 1; bsy0 = $urandom_range(2, 12); end
      end else begin
        bsy0--; if (bsy0 == 0) rd_done0 = 1;
      end
      if (bsy1 == 0) begin
        if ($urandom_range(0, 9) == 0) begin rd_start1 = 1; bsy1 = $urandom_range(2, 12); end
      end else begin
        bsy1--; if (bsy1 == 0) rd_done1 = 1;
      end
    end
    @(negedge clk);
    ch0_rdy = 0; ch1_rdy = 0; rd_start0 = 0; rd_start1 = 0; rd_done0 = 0; rd_done1 = 0;
    cyc(30);
    if (seed_v == -1) $display("seed");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule